// File: doc/BRIEF.md
# Multiply Rounding Selector

This block is the last stage of a floating-point multiplier. It receives the product fraction as three partial products that have not yet been added. Their sum modulo 2^64, read as a fixed-point number with weight 2^-64 on bit 0, always lies in [1/4, 1). The block also receives a tentative exponent. It returns a 53-bit normalized fraction, rounded half-up, and the matching exponent. It does not do a full add and then round. Instead it runs two speculative paths side by side, and each path places its rounding increment in the empty low bits of the third partial product before a single 3-to-2 reduction and a single carry-propagate add.

One path assumes that the result is in [1/2, 1). It rounds at half a result lsb. The other path assumes [1/4, 1/2). It rounds at a quarter of that lsb, then shifts its sum left by one place and lowers the exponent by one. A late select keeps the quarter-lsb path only when its rounded sum is still below 1/2. In every other case it keeps the half-lsb path with the exponent unchanged. The rounded product can never reach 1, so no second normalization follows the select. The outputs come from registers one cycle after an accepted input.

Top module: `mul_round_select`

## Requirements
- R1: `out_valid` is 0 while `rst_n` is low. Otherwise it equals the value `in_valid` had on the previous rising clock edge, so a result appears exactly one cycle after its input.
- R2: The unrounded value is X = (pp_a + pp_b + pp_c) mod 2^64, with weight 2^-64 on bit 0. Inputs are only legal when 2^62 <= X <= 2^64 - 2^10 - 1.
- R3: When X + 2^9 >= 2^63, `frac_out` = bits [63:11] of X + 2^10 and `exp_out` = `exp_in`.
- R4: When X + 2^9 < 2^63, `frac_out` = bits [62:10] of X + 2^9 and `exp_out` = `exp_in` - 1 (modulo 2^11).
- R5: A value just below 1/2 that rounds up to 1/2 (for example X = 2^63 - 2^9) is reported by the half-lsb path. The result is `frac_out` = 2^52 with `exp_out` = `exp_in`.
- R6: When `out_valid` is 1, bit 52 of `frac_out` is 1 and the fraction is never all-zero from wrap-around, even at the largest legal X.
- R7: The low 11 bits of `pp_c` must be zero with `in_valid`. Those bit positions of `pp_a` and `pp_b` still take part in the sum.
- R8: Exact ties round up in both ranges. X = 2^63 + 2^10 gives 2^52 + 1. X = 2^62 + 2^9 gives 2^52 + 1 with the exponent decremented.
- R9: While `in_valid` is 0, `frac_out` and `exp_out` keep the last result, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Partial products and exponent are valid this cycle |
| pp_a | input | 64 | First partial product |
| pp_b | input | 64 | Second partial product |
| pp_c | input | 64 | Third partial product; low 11 bits must be zero |
| exp_in | input | 11 | Tentative exponent for a result in [1/2, 1) |
| out_valid | output | 1 | Result registers hold a new result |
| frac_out | output | 53 | Rounded normalized fraction, bit 52 is the leading one |
| exp_out | output | 11 | Exponent that goes with `frac_out` |

## Verification
Some properties are checked on every cycle:
- the one-cycle valid latency;
- that a delivered fraction is normalized;
- that the delivered exponent is either the input exponent or one less;
- that the half-lsb path really is in the upper range whenever it is chosen;
- the rule that the third partial product has zero low bits.

Other behaviour can only be shown by the bench's directed scenarios:
- the exact rounded values;
- the direction of each tie;
- the carry of a just-below-half value into the upper range;
- that results hold through idle cycles.

The bench splits each chosen product value into three different partial products, so carries through the reduction are exercised.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
   // Carry-propagate adder implementation choices
   typedef enum logic [0:0] {
      ADD_BEHAV = 1'b0,
      ADD_CSEL  = 1'b1
   } adder_arch_e;

   localparam int unsigned DEF_PP_W   = 64;
   localparam int unsigned DEF_FRAC_W = 53;
   localparam int unsigned DEF_EXP_W  = 11;
   localparam int unsigned DEF_BLK_W  = 8;
endpackage

// File: rtl/mrs_csa.sv
// Bitwise 3:2 carry-save reducer; the carry vector is pre-shifted by one.
module mrs_csa #(
   parameter int unsigned W = 64
) (
   input  logic [W-1:0] in_x,
   input  logic [W-1:0] in_y,
   input  logic [W-1:0] in_z,
   output logic [W-1:0] sum_o,
   output logic [W-1:0] car_o
);
   initial begin
      if (W < 2) $error("mrs_csa: W must be at least 2");
   end

   logic [W-2:0] maj;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign sum_o[i] = in_x[i] ^ in_y[i] ^ in_z[i];
      if (i < W - 1) begin : g_maj
         assign maj[i] = (in_x[i] & in_y[i]) | (in_x[i] & in_z[i]) | (in_y[i] & in_z[i]);
      end
   end

   assign car_o = {maj, 1'b0};
endmodule

// File: rtl/mrs_cpa.sv
// Modulo-2^W carry-propagate adder; ARCH selects the implementation.
module mrs_cpa #(
   parameter int unsigned        W     = 64,
   parameter int unsigned        BLK_W = 8,
   parameter mrs_pkg::adder_arch_e ARCH = mrs_pkg::ADD_CSEL
) (
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   output logic [W-1:0] sum_o
);
   localparam int unsigned NBLK = W / BLK_W;

   initial begin
      if (BLK_W == 0 || (W % BLK_W) != 0)
         $error("mrs_cpa: W must be a multiple of BLK_W");
   end

   if (ARCH == mrs_pkg::ADD_BEHAV) begin : g_behav
      assign sum_o = op_a + op_b;
   end else begin : g_csel
      logic [NBLK-1:0] blk_cin;
      assign blk_cin[0] = 1'b0;
      for (genvar g = 0; g < NBLK; g++) begin : g_blk
         if (g < NBLK - 1) begin : g_mid
            logic [BLK_W:0] s_zero;
            logic [BLK_W:0] s_one;
            assign s_zero = {1'b0, op_a[g*BLK_W +: BLK_W]} + {1'b0, op_b[g*BLK_W +: BLK_W]};
            assign s_one  = {1'b0, op_a[g*BLK_W +: BLK_W]} + {1'b0, op_b[g*BLK_W +: BLK_W]}
                            + (BLK_W+1)'(1);
            assign sum_o[g*BLK_W +: BLK_W] = blk_cin[g] ? s_one[BLK_W-1:0] : s_zero[BLK_W-1:0];
            assign blk_cin[g+1] = blk_cin[g] ? s_one[BLK_W] : s_zero[BLK_W];
         end else begin : g_top
            logic [BLK_W-1:0] t_zero;
            logic [BLK_W-1:0] t_one;
            assign t_zero = op_a[g*BLK_W +: BLK_W] + op_b[g*BLK_W +: BLK_W];
            assign t_one  = op_a[g*BLK_W +: BLK_W] + op_b[g*BLK_W +: BLK_W] + BLK_W'(1);
            assign sum_o[g*BLK_W +: BLK_W] = blk_cin[g] ? t_one : t_zero;
         end
      end
   end
endmodule

// File: rtl/mrs_path.sv
// One speculative rounding path: inject increment, reduce 3:2, add.
module mrs_path #(
   parameter int unsigned        W       = 64,
   parameter int unsigned        RND_POS = 10,
   parameter int unsigned        ZERO_W  = 11,
   parameter int unsigned        BLK_W   = 8,
   parameter mrs_pkg::adder_arch_e ARCH  = mrs_pkg::ADD_CSEL
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         chk_en,
   input  logic [W-1:0] pp_a,
   input  logic [W-1:0] pp_b,
   input  logic [W-1:0] pp_c,
   output logic [W-1:0] sum_o
);
   initial begin
      if (RND_POS >= ZERO_W) $error("mrs_path: increment must land in the empty low bits");
      if (ZERO_W >= W)       $error("mrs_path: empty field wider than operand");
   end

   logic [W-1:0] c_inj;
   logic [W-1:0] red_s;
   logic [W-1:0] red_c;

   assign c_inj = pp_c | (W'(1) << RND_POS);

   mrs_csa #(.W(W)) i_csa (
      .in_x (pp_a),
      .in_y (pp_b),
      .in_z (c_inj),
      .sum_o(red_s),
      .car_o(red_c)
   );

   mrs_cpa #(.W(W), .BLK_W(BLK_W), .ARCH(ARCH)) i_cpa (
      .op_a (red_s),
      .op_b (red_c),
      .sum_o(sum_o)
   );

   // R7: the increment is only exact when the injected field starts empty
   assert_cfield_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en |-> (pp_c[ZERO_W-1:0] == '0));
endmodule

// File: rtl/mul_round_select.sv
module mul_round_select #(
   parameter int unsigned        PP_W   = mrs_pkg::DEF_PP_W,
   parameter int unsigned        FRAC_W = mrs_pkg::DEF_FRAC_W,
   parameter int unsigned        EXP_W  = mrs_pkg::DEF_EXP_W,
   parameter int unsigned        BLK_W  = mrs_pkg::DEF_BLK_W,
   parameter mrs_pkg::adder_arch_e ARCH = mrs_pkg::ADD_CSEL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [PP_W-1:0]   pp_a,
   input  logic [PP_W-1:0]   pp_b,
   input  logic [PP_W-1:0]   pp_c,
   input  logic [EXP_W-1:0]  exp_in,
   output logic              out_valid,
   output logic [FRAC_W-1:0] frac_out,
   output logic [EXP_W-1:0]  exp_out
);
   localparam int unsigned HI_LSB  = PP_W - FRAC_W;   // lsb index, upper range
   localparam int unsigned HI_RND  = HI_LSB - 1;      // half lsb
   localparam int unsigned LO_RND  = HI_LSB - 2;      // quarter lsb

   initial begin
      if (FRAC_W + 3 > PP_W) $error("mul_round_select: need at least three bits below the fraction");
      if (EXP_W < 2)         $error("mul_round_select: exponent too narrow");
   end

   logic [PP_W-1:0]   sum_hi;
   logic [PP_W-1:0]   sum_lo;
   logic              pick_lo;
   logic [FRAC_W-1:0] frac_nxt;
   logic [EXP_W-1:0]  exp_nxt;

   mrs_path #(.W(PP_W), .RND_POS(HI_RND), .ZERO_W(HI_LSB), .BLK_W(BLK_W), .ARCH(ARCH)) i_path_hi (
      .clk(clk), .rst_n(rst_n), .chk_en(in_valid),
      .pp_a(pp_a), .pp_b(pp_b), .pp_c(pp_c), .sum_o(sum_hi)
   );

   mrs_path #(.W(PP_W), .RND_POS(LO_RND), .ZERO_W(HI_LSB), .BLK_W(BLK_W), .ARCH(ARCH)) i_path_lo (
      .clk(clk), .rst_n(rst_n), .chk_en(in_valid),
      .pp_a(pp_a), .pp_b(pp_b), .pp_c(pp_c), .sum_o(sum_lo)
   );

   // Late select: quarter-lsb result kept only while it stays below one half
   always_comb begin
      pick_lo = ~sum_lo[PP_W-1];
      if (pick_lo) begin
         frac_nxt = sum_lo[PP_W-2 -: FRAC_W];
         exp_nxt  = exp_in - EXP_W'(1);
      end else begin
         frac_nxt = sum_hi[PP_W-1 -: FRAC_W];
         exp_nxt  = exp_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         frac_out  <= '0;
         exp_out   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            frac_out <= frac_nxt;
            exp_out  <= exp_nxt;
         end
      end
   end

   assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   assert_frac_normalized_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> frac_out[FRAC_W-1]);

   // R3 / R4: exponent is either kept or lowered by exactly one
   assert_exp_adjust_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (exp_out == $past(exp_in) || exp_out == $past(exp_in) - EXP_W'(1)));

   // R5: whenever the half-lsb path wins, its own sum is in the upper range
   assert_hi_path_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !pick_lo) |-> sum_hi[PP_W-1]);
endmodule

// File: tb/test_mul_round_select.sv
module test_mul_round_select;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] pp_a = '0, pp_b = '0, pp_c = '0;
   logic [10:0] exp_in = '0;
   logic        out_valid;
   logic [52:0] frac_out;
   logic [10:0] exp_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   mul_round_select i_mul_round_select (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .pp_a(pp_a), .pp_b(pp_b), .pp_c(pp_c), .exp_in(exp_in),
      .out_valid(out_valid), .frac_out(frac_out), .exp_out(exp_out)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
      end
   endtask

   // Expected result from the requirement text (R3/R4)
   function automatic void model(input logic [63:0] x, input logic [10:0] e,
                                 output logic [52:0] f, output logic [10:0] eo);
      logic [64:0] q;
      logic [64:0] h;
      q = {1'b0, x} + 65'(2**9);
      h = {1'b0, x} + 65'(2**10);
      if (q < 65'(64'h8000_0000_0000_0000)) begin
         f  = q[62:10];
         eo = e - 11'd1;
      end else begin
         f  = h[63:11];
         eo = e;
      end
   endfunction

   // Split x into three partial products, pp_c with empty low field (R7)
   task automatic drive(input logic [63:0] x, input logic [63:0] a, input logic [63:0] c_raw,
                        input logic [10:0] e);
      logic [63:0] c;
      c = {c_raw[63:11], 11'b0};
      pp_a = a; pp_c = c; pp_b = x - a - c; exp_in = e; in_valid = 1'b1;
   endtask

   task automatic one_shot(input string req, input logic [63:0] x, input logic [10:0] e);
      logic [52:0] f;
      logic [10:0] eo;
      model(x, e, f, eo);
      @(negedge clk);
      drive(x, {$urandom, $urandom}, {$urandom, $urandom}, e);
      @(negedge clk);
      in_valid = 1'b0;
      check({req, " valid"}, 64'(out_valid), 64'd1);
      check({req, " frac"}, 64'(frac_out), 64'(f));
      check({req, " exp"}, 64'(exp_out), 64'(eo));
   endtask

   task automatic t_reset;
      check("R1 reset valid", 64'(out_valid), 64'd0);
      check("R1 reset frac", 64'(frac_out), 64'd0);
   endtask

   task automatic t_ranges;
      one_shot("R3 upper", 64'hC123_4567_89AB_CDEF, 11'd1023);
      one_shot("R4 lower", 64'h5123_4567_89AB_CDEF, 11'd1023);
      one_shot("R2 min", 64'h4000_0000_0000_0000, 11'd5);
      one_shot("R6 max", 64'hFFFF_FFFF_FFFF_FBFF, 11'd700);
      one_shot("R4 exp wrap", 64'h6000_0000_0000_0000, 11'd0);
   endtask

   task automatic t_boundaries;
      one_shot("R5 round to half", 64'h7FFF_FFFF_FFFF_FE00, 11'd300);
      one_shot("R5 just below", 64'h7FFF_FFFF_FFFF_FDFF, 11'd300);
      one_shot("R8 tie upper", 64'h8000_0000_0000_0400, 11'd10);
      one_shot("R8 below tie upper", 64'h8000_0000_0000_03FF, 11'd10);
      one_shot("R8 tie lower", 64'h4000_0000_0000_0200, 11'd10);
      one_shot("R8 below tie lower", 64'h4000_0000_0000_01FF, 11'd10);
   endtask

   // R7: low bits of pp_a/pp_b feed the sum, checked via carries into lsb
   task automatic t_low_bits;
      logic [52:0] f;
      logic [10:0] eo;
      model(64'h9000_0000_0000_07FF, 11'd50, f, eo);
      @(negedge clk);
      pp_a = 64'h0000_0000_0000_03FF; pp_b = 64'h0000_0000_0000_0400;
      pp_c = 64'h9000_0000_0000_0000; exp_in = 11'd50; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R7 low bits of a/b", 64'(frac_out), 64'(f));
   endtask

   task automatic t_stream;
      logic [63:0] xs [6];
      logic [52:0] f;
      logic [10:0] eo;
      for (int i = 0; i < 6; i++) begin
         xs[i] = {2'b01, 62'h0} + {$urandom, $urandom} % 64'hBFFF_FFFF_FFFF_F000;
      end
      @(negedge clk);
      for (int i = 0; i < 6; i++) begin
         drive(xs[i], {$urandom, $urandom}, {$urandom, $urandom}, 11'(100 + i));
         @(negedge clk);
         model(xs[i], 11'(100 + i), f, eo);
         check("R1 stream valid", 64'(out_valid), 64'd1);
         check("R2 stream frac", 64'(frac_out), 64'(f));
         check("R2 stream exp", 64'(exp_out), 64'(eo));
      end
      in_valid = 1'b0;
   endtask

   task automatic t_hold;
      logic [52:0] f0;
      logic [10:0] e0;
      one_shot("R9 setup", 64'hA5A5_A5A5_A5A5_A5A5, 11'd77);
      f0 = frac_out; e0 = exp_out;
      for (int i = 0; i < 4; i++) begin
         pp_a = {$urandom, $urandom}; pp_b = {$urandom, $urandom};
         pp_c = {$urandom, 11'b0, 21'(i)} & 64'hFFFF_FFFF_FFFF_F800;
         exp_in = 11'(i);
         @(negedge clk);
         check("R9 hold frac", 64'(frac_out), 64'(f0));
         check("R9 hold exp", 64'(exp_out), 64'(e0));
         check("R1 idle valid", 64'(out_valid), 64'd0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_ranges();
      t_boundaries();
      t_low_bits();
      t_stream();
      t_hold();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule